// File: doc/BRIEF.md
# Modem Host Byte Port

This block sits between a host processor and a modem engine. The host sees two byte-wide registers, and one address input picks between them. A write to the data register queues a byte for the engine. A read of the data register takes the oldest byte the engine has produced. The second register is a status/control byte. It reports how full both queues are, carries an escape flag and two legacy handshake flags, and holds the interrupt mask and interrupt flag behind a level interrupt output.

On the engine side, two valid/ready byte streams connect to the queues. The outbound stream (`core_tx_*`) presents the head of the transmit queue whenever that queue is non-empty. A byte leaves only in a cycle where valid and ready are both high, and data stays stable while ready is held low. The inbound stream (`core_rx_*`) is accepted whenever the receive queue has room. Ready drops while the queue holds 12 bytes, and a byte offered then is not taken. The engine can also pulse an event input that sets the interrupt flag, and it receives a one-cycle escape request.

Top module: `modem_host_port`

## Requirements
- R1: With `host_sel`=0, a `host_wr` strobe appends `host_wdata` to the transmit queue, and the bytes leave on the outbound stream in write order. The outbound data stays stable while valid is high and ready is low.
- R2: The receive queue holds 12 bytes. `core_rx_ready` is 0 while it is full. With `host_sel`=0, a `host_rd` strobe returns the oldest byte on `host_rdata` in the same cycle and removes it.
- R3: The status byte (`host_sel`=1) has bit 7 receive-almost-full, bit 6 transmit-almost-empty, bit 5 receive-empty, bit 4 interrupt mask, bit 3 interrupt flag, bit 2 escape, bit 1 request-to-send and bit 0 clear-to-send. After reset it reads 0x63.
- R4: Bit 7 is 1 when the receive queue holds 10 or more bytes and 0 otherwise. Bit 5 is 1 exactly when the receive queue is empty.
- R5: The transmit queue holds 12 bytes. Bit 6 is 1 when it holds fewer than 3 bytes. A data write while it is full is dropped.
- R6: A data-register read while the receive queue is empty returns 0x00 and removes nothing.
- R7: A rising edge of bit 7 or bit 6 raises `irq`, which stays high until the host writes the status byte with that bit's position at 0. Writing 1 at those positions has no effect.
- R8: A `core_evt` pulse sets bit 3, and a host read of the status byte clears it. When bit 4 is 1, a rising edge of bit 3 also raises `irq`, which drops once bit 3 is cleared. When bit 4 is 0, bit 3 does not affect `irq`.
- R9: Host writes to bits 5 and 3 are ignored. Bits 4, 1 and 0 store the written value.
- R10: Each status write with bit 2 = 1 gives a one-cycle `esc_req` pulse. Bit 2 then reads 1 until the host writes it 0, and that write gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Register select: 0 data, 1 status/control |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Selected register value, combinational |
| core_tx_valid | output | 1 | Outbound byte available |
| core_tx_ready | input | 1 | Engine accepts outbound byte |
| core_tx_data | output | 8 | Outbound byte |
| core_rx_valid | input | 1 | Engine offers inbound byte |
| core_rx_ready | output | 1 | Receive queue has room |
| core_rx_data | input | 8 | Inbound byte |
| core_evt | input | 1 | Engine interrupt event pulse |
| esc_req | output | 1 | One-cycle escape request to the engine |
| irq | output | 1 | Level interrupt to the host |

## Verification
Properties check the following on every cycle:
- an empty-queue read returns zero;
- ready is low while the receive queue is full;
- outbound data holds steady under back-pressure;
- each escape pulse comes from a status write with bit 2 set and lasts one cycle;
- a host write never changes the interrupt flag.

Only the bench scenarios can show the rest:
- the byte ordering through both queues;
- the almost-full and almost-empty thresholds and the dropped thirteenth write;
- `irq` rising on each qualifying edge, staying high, and dropping only after the matching clear, with the mask gating the event path;
- the exact reset byte.

// File: rtl/host_port_pkg.sv
package host_port_pkg;
  localparam int BIT_RXAF  = 7;
  localparam int BIT_TXAE  = 6;
  localparam int BIT_RXEMP = 5;
  localparam int BIT_MASK  = 4;
  localparam int BIT_INT   = 3;
  localparam int BIT_ESC   = 2;
  localparam int BIT_RTS   = 1;
  localparam int BIT_CTS   = 0;
  localparam logic [7:0] STAT_RESET = 8'h63;
  localparam int NUM_IRQ_SRC = 3;
endpackage

// File: rtl/hp_fifo.sv
module hp_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 12,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/hp_irq_ctrl.sv
module hp_irq_ctrl #(
  parameter int NSRC = 3,
  parameter logic [NSRC-1:0] RST_LVL = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] lvl,
  input  logic [NSRC-1:0] en,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] pend,
  output logic            irq
);
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic lvl_q, pend_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lvl_q  <= RST_LVL[g];
        pend_q <= 1'b0;
      end else begin
        lvl_q <= lvl[g];
        if (lvl[g] && !lvl_q && en[g]) pend_q <= 1'b1;
        else if (clr[g])               pend_q <= 1'b0;
      end
    end
    assign pend[g] = pend_q;
  end

  assign irq = |pend;
endmodule

// File: rtl/hp_status_regs.sv
module hp_status_regs
  import host_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_af,
  input  logic       tx_ae,
  input  logic       rx_empty,
  input  logic       st_wr,
  input  logic       st_rd,
  input  logic       wd_mask,
  input  logic       wd_esc,
  input  logic       wd_rts,
  input  logic       wd_cts,
  input  logic       clr_rx,
  input  logic       clr_tx,
  input  logic       core_evt,
  output logic [7:0] stat,
  output logic       esc_req,
  output logic       irq
);
  logic mask_q, int_q, esc_q, rts_q, cts_q;
  logic [NUM_IRQ_SRC-1:0] src_lvl, src_en, src_clr, src_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= STAT_RESET[BIT_MASK];
      esc_q   <= STAT_RESET[BIT_ESC];
      rts_q   <= STAT_RESET[BIT_RTS];
      cts_q   <= STAT_RESET[BIT_CTS];
      int_q   <= STAT_RESET[BIT_INT];
      esc_req <= 1'b0;
    end else begin
      esc_req <= st_wr && wd_esc;
      if (st_wr) begin
        mask_q <= wd_mask;
        esc_q  <= wd_esc;
        rts_q  <= wd_rts;
        cts_q  <= wd_cts;
      end
      if (core_evt)   int_q <= 1'b1;
      else if (st_rd) int_q <= 1'b0;
    end
  end

  // source 0: receive almost full, 1: transmit almost empty, 2: event flag
  assign src_lvl = {int_q, tx_ae, rx_af};
  assign src_en  = {mask_q, 1'b1, 1'b1};
  assign src_clr = {~int_q, st_wr && clr_tx, st_wr && clr_rx};

  hp_irq_ctrl #(
    .NSRC(NUM_IRQ_SRC),
    .RST_LVL({STAT_RESET[BIT_INT], STAT_RESET[BIT_TXAE], STAT_RESET[BIT_RXAF]})
  ) u_irq (
    .clk(clk), .rst_n(rst_n), .lvl(src_lvl), .en(src_en),
    .clr(src_clr), .pend(src_pend), .irq(irq)
  );

  always_comb begin
    stat            = '0;
    stat[BIT_RXAF]  = rx_af;
    stat[BIT_TXAE]  = tx_ae;
    stat[BIT_RXEMP] = rx_empty;
    stat[BIT_MASK]  = mask_q;
    stat[BIT_INT]   = int_q;
    stat[BIT_ESC]   = esc_q;
    stat[BIT_RTS]   = rts_q;
    stat[BIT_CTS]   = cts_q;
  end
endmodule

// File: rtl/modem_host_port.sv
module modem_host_port
  import host_port_pkg::*;
#(
  parameter int RX_DEPTH  = 12,
  parameter int TX_DEPTH  = 12,
  parameter int RX_AF_LVL = 10,
  parameter int TX_AE_LVL = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_sel,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       core_tx_valid,
  input  logic       core_tx_ready,
  output logic [7:0] core_tx_data,
  input  logic       core_rx_valid,
  output logic       core_rx_ready,
  input  logic [7:0] core_rx_data,
  input  logic       core_evt,
  output logic       esc_req,
  output logic       irq
);
  localparam int RXCW = $clog2(RX_DEPTH + 1);
  localparam int TXCW = $clog2(TX_DEPTH + 1);

  logic [RXCW-1:0] rx_count;
  logic [TXCW-1:0] tx_count;
  logic [7:0]      rx_head, stat_byte;
  logic            rx_full, rx_empty, tx_full, tx_empty;
  logic            rx_af, tx_ae;
  logic            data_wr, data_rd, st_wr, st_rd;

  assign data_wr = host_wr && !host_sel;
  assign data_rd = host_rd && !host_sel;
  assign st_wr   = host_wr && host_sel;
  assign st_rd   = host_rd && host_sel;

  hp_fifo #(.W(8), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(data_wr), .wdata(host_wdata),
    .pop(core_tx_ready), .head(core_tx_data), .count(tx_count),
    .full(tx_full), .empty(tx_empty)
  );

  hp_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(core_rx_valid), .wdata(core_rx_data),
    .pop(data_rd), .head(rx_head), .count(rx_count),
    .full(rx_full), .empty(rx_empty)
  );

  assign core_tx_valid = !tx_empty;
  assign core_rx_ready = !rx_full;
  assign rx_af = (rx_count >= RXCW'(RX_AF_LVL));
  assign tx_ae = (tx_count <  TXCW'(TX_AE_LVL));

  hp_status_regs u_stat (
    .clk(clk), .rst_n(rst_n), .rx_af(rx_af), .tx_ae(tx_ae),
    .rx_empty(rx_empty), .st_wr(st_wr), .st_rd(st_rd),
    .wd_mask(host_wdata[BIT_MASK]), .wd_esc(host_wdata[BIT_ESC]),
    .wd_rts(host_wdata[BIT_RTS]), .wd_cts(host_wdata[BIT_CTS]),
    .clr_rx(!host_wdata[BIT_RXAF]), .clr_tx(!host_wdata[BIT_TXAE]),
    .core_evt(core_evt), .stat(stat_byte), .esc_req(esc_req), .irq(irq)
  );

  assign host_rdata = host_sel ? stat_byte : (rx_empty ? 8'h00 : rx_head);
endmodule

// File: rtl/hp_checker.sv
module hp_checker #(
  parameter int RX_DEPTH = 12,
  localparam int RXCW = $clog2(RX_DEPTH + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            host_sel,
  input logic            host_wr,
  input logic            host_rd,
  input logic [7:0]      host_wdata,
  input logic [7:0]      host_rdata,
  input logic            core_tx_valid,
  input logic            core_tx_ready,
  input logic [7:0]      core_tx_data,
  input logic            core_rx_ready,
  input logic            core_evt,
  input logic            esc_req,
  input logic [7:0]      stat_byte,
  input logic [RXCW-1:0] rx_count
);
  // R1
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_tx_valid && !core_tx_ready) |=> (core_tx_valid && $stable(core_tx_data)));

  // R2
  rx_full_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == RXCW'(RX_DEPTH)) |-> !core_rx_ready);

  // R6
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_sel && rx_count == '0) |-> (host_rdata == 8'h00));

  // R9
  ro_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_sel && !host_rd && !core_evt) |=> (stat_byte[3] == $past(stat_byte[3])));

  // R10
  esc_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    esc_req |-> $past(host_wr && host_sel && host_wdata[2]));

  // R10
  esc_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (esc_req && !(host_wr && host_sel && host_wdata[2])) |=> !esc_req);
endmodule

bind modem_host_port hp_checker #(.RX_DEPTH(RX_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
  .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
  .core_tx_valid(core_tx_valid), .core_tx_ready(core_tx_ready),
  .core_tx_data(core_tx_data), .core_rx_ready(core_rx_ready),
  .core_evt(core_evt), .esc_req(esc_req), .stat_byte(stat_byte),
  .rx_count(rx_count)
);

// File: tb/sim_modem_host_port.sv
module sim_modem_host_port;
  logic clk = 0, rst_n = 0;
  logic host_sel = 0, host_wr = 0, host_rd = 0;
  logic [7:0] host_wdata = 0, host_rdata;
  logic core_tx_valid, core_tx_ready = 0;
  logic [7:0] core_tx_data;
  logic core_rx_valid = 0, core_rx_ready;
  logic [7:0] core_rx_data = 0;
  logic core_evt = 0, esc_req, irq;

  int total = 0, bad = 0, esc_cnt = 0;
  byte unsigned txq[$], rxq[$];
  logic m_mask = 0, m_int = 0, m_esc = 0, m_rts = 1, m_cts = 1;

  always #2 clk = ~clk;

  modem_host_port u0 (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .core_tx_valid(core_tx_valid), .core_tx_ready(core_tx_ready),
    .core_tx_data(core_tx_data), .core_rx_valid(core_rx_valid),
    .core_rx_ready(core_rx_ready), .core_rx_data(core_rx_data),
    .core_evt(core_evt), .esc_req(esc_req), .irq(irq)
  );

  always @(posedge clk) if (rst_n && esc_req) esc_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_stat();
    return {rxq.size() >= 10, txq.size() < 3, rxq.size() == 0,
            m_mask, m_int, m_esc, m_rts, m_cts};
  endfunction

  task automatic host_write(input logic sel, input logic [7:0] d);
    @(negedge clk);
    host_sel = sel; host_wdata = d; host_wr = 1;
    @(negedge clk);
    host_wr = 0;
    if (!sel) begin
      if (txq.size() < 12) txq.push_back(d);
    end else begin
      m_mask = d[4]; m_esc = d[2]; m_rts = d[1]; m_cts = d[0];
    end
  endtask

  task automatic host_read(input logic sel, output logic [7:0] d);
    @(negedge clk);
    host_sel = sel; host_rd = 1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 0;
    if (!sel) begin
      if (rxq.size() > 0) void'(rxq.pop_front());
    end else m_int = 0;
  endtask

  task automatic read_data(input string req);
    logic [7:0] d, e;
    e = (rxq.size() > 0) ? rxq[0] : 8'h00;
    host_read(0, d);
    chk(req, d, e);
  endtask

  task automatic check_stat(input string req);
    logic [7:0] d, e;
    e = exp_stat();
    host_read(1, d);
    chk(req, d, e);
  endtask

  task automatic core_take(input string req);
    @(negedge clk);
    core_tx_ready = 1;
    #1;
    chk(req, core_tx_valid, txq.size() > 0);
    if (txq.size() > 0) chk(req, core_tx_data, txq.pop_front());
    @(negedge clk);
    core_tx_ready = 0;
  endtask

  task automatic core_push(input logic [7:0] d, input string req);
    @(negedge clk);
    core_rx_valid = 1; core_rx_data = d;
    #1;
    chk(req, core_rx_ready, rxq.size() < 12);
    if (rxq.size() < 12) rxq.push_back(d);
    @(negedge clk);
    core_rx_valid = 0;
  endtask

  task automatic pulse_evt();
    @(negedge clk);
    core_evt = 1;
    @(negedge clk);
    core_evt = 0;
    m_int = 1;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int e0;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R3 reset value
    #1;
    chk("R3 irq reset", irq, 0);
    chk("R2 rx ready reset", core_rx_ready, 1);
    chk("R1 tx valid reset", core_tx_valid, 0);
    check_stat("R3 reset 0x63");
    chk("R3 literal", exp_stat(), 8'h63);

    // R1 ordering, R7 transmit edge
    host_write(0, 8'hA1); host_write(0, 8'hB2); host_write(0, 8'hC3);
    check_stat("R5 txae low at 3");
    for (int i = 0; i < 3; i++) core_take("R1 tx order");
    settle();
    chk("R7 irq on txae rise", irq, 1);
    settle();
    chk("R7 irq held", irq, 1);
    host_write(1, 8'hC0);
    settle();
    chk("R7 write 1 keeps irq", irq, 1);
    host_write(1, 8'h80);
    settle();
    chk("R7 irq cleared by bit6=0", irq, 0);

    // R6 empty read
    read_data("R6 empty read zero");
    core_push(8'h5A, "R2 push");
    read_data("R6 no pointer move");
    check_stat("R4 empty again");

    // R2 R4 receive fill
    for (int i = 0; i < 9; i++) core_push(8'h10 + 8'(i), "R2 push");
    check_stat("R4 rxaf low at 9");
    settle();
    chk("R7 no irq below threshold", irq, 0);
    core_push(8'h19, "R2 push");
    check_stat("R4 rxaf high at 10");
    settle();
    chk("R7 irq on rxaf rise", irq, 1);
    core_push(8'h1A, "R2 push");
    core_push(8'h1B, "R2 push");
    core_push(8'hEE, "R2 full refuses");
    host_write(1, 8'h40);
    settle();
    chk("R7 irq cleared by bit7=0", irq, 0);
    for (int i = 0; i < 12; i++) read_data("R2 rx order");
    read_data("R6 empty after drain");
    check_stat("R4 empty status");

    // R5 transmit full
    for (int i = 0; i < 13; i++) host_write(0, 8'h30 + 8'(i));
    check_stat("R5 txae low when full");
    for (int i = 0; i < 12; i++) core_take("R5 tx order");
    core_take("R5 13th dropped");
    host_write(1, 8'h80);
    settle();
    chk("R7 cleared", irq, 0);

    // R8 event flag
    pulse_evt();
    settle();
    chk("R8 mask0 no irq", irq, 0);
    check_stat("R8 int flag set");
    check_stat("R8 int cleared by read");
    host_write(1, 8'h10);
    pulse_evt();
    settle();
    chk("R8 mask1 irq", irq, 1);
    check_stat("R8 int set masked");
    settle();
    chk("R8 irq drops after read", irq, 0);

    // R9 read-only bits
    host_write(1, 8'h2B);
    check_stat("R9 ro bits ignored");

    // R10 escape
    e0 = esc_cnt;
    host_write(1, 8'h04);
    settle();
    chk("R10 one pulse", esc_cnt - e0, 1);
    check_stat("R10 esc bit held");
    settle();
    check_stat("R10 esc still held");
    host_write(1, 8'h00);
    settle();
    chk("R10 no pulse on clear", esc_cnt - e0, 1);
    check_stat("R10 esc cleared");

    // random mix
    for (int n = 0; n < 400; n++) begin
      case ($urandom % 4)
        0: host_write(0, 8'($urandom));
        1: read_data("R2 random read");
        2: core_take("R1 random take");
        default: core_push(8'($urandom), "R2 random push");
      endcase
      if (n % 8 == 0) check_stat("R4 random status");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule